// File: doc/BRIEF.md
# NAND Page Buffer Address Mapper

This block converts a byte-level access into a NAND page, described by a start column and a byte count, into a series of accesses to a flash controller's internal buffer RAM. The page is treated as a main data area followed by a spare (out-of-band) area. In the buffer RAM, the main area is a contiguous region that starts at address zero. The spare bytes are spread across eight separate 64-byte buffers starting at address 0x1000. Each spare buffer holds an even-sized share of the spare area. Any spare bytes beyond those shares land in the last buffer.

A request gives the start column, the length, the page size (as a power-of-two count of 512-byte sectors), the spare size in bytes and a spare-only flag. The block then offers one (buffer address, chunk length) pair per cycle on a valid/ready handshake. No chunk crosses the end of the main area or the end of a non-final spare buffer. A data mover downstream copies each chunk. The block reports the running column and pulses `done` once the whole request has been handed out.

Top module: `nand_page_mapper`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `chunk_valid` is 0, `done` is 0 and `col_out` is 0.
- R2: A main-area chunk has buffer address equal to the current column. Its length is the smaller of the bytes remaining and (page bytes − column), where page bytes = 512 << `req_page_log2`.
- R3: When a main-area chunk reaches the page end and bytes remain, the next chunk is in the spare area at spare offset 0.
- R4: A request whose start column is at or above the page size begins in the spare area at offset (column − page bytes).
- R5: With `req_spare_only` set and a start column below the page size, the request begins in the spare area at offset equal to the column.
- R6: The share per spare buffer is (spare size >> `req_page_log2`) with bit 0 cleared. For spare offset f, the buffer index is k = min(f / share, 7), and the address is 0x1000 + k·0x40 + (f − k·share). A zero share selects index 7.
- R7: A chunk in spare buffer k < 7 has length min(remaining, share − (f − k·share)). A chunk in buffer 7 carries all remaining bytes.
- R8: Each accepted chunk (`chunk_valid` and `chunk_ready` both high) advances `col_out` by its length. After the last chunk, `col_out` equals start column + length.
- R9: While `chunk_valid` is high and `chunk_ready` is low, the chunk address and length hold steady.
- R10: `done` pulses for one cycle in the cycle after the last chunk is accepted. A zero-length request offers no chunk and pulses `done` in the cycle after acceptance. No chunk has zero length, and `done` and `chunk_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Mapper idle and able to take a request |
| req_col | input | COL_W | Start column within the page |
| req_len | input | LEN_W | Byte count of the request |
| req_page_log2 | input | LOG_W | log2 of the number of 512-byte sectors per page |
| req_spare_size | input | SPARE_W | Spare area size in bytes |
| req_spare_only | input | 1 | Direct the whole request to the spare area |
| chunk_valid | output | 1 | Chunk pair on offer |
| chunk_ready | input | 1 | Consumer takes the chunk this cycle |
| chunk_addr | output | ADDR_W | Buffer RAM byte address of the chunk |
| chunk_len | output | LEN_W | Byte length of the chunk |
| col_out | output | COL_W | Running column |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bench uses the default parameters: 16-bit column and length, 8-bit spare size, 2-bit page exponent, 13-bit buffer address and eight 64-byte spare buffers. These values cover every page size from 512 to 4096 bytes and spare sizes up to 255. As a result, the bench exercises both odd shares that need even rounding and offsets large enough to clamp into buffer 7, where the remainder accumulates. Random requests are limited to shares of at most 64 bytes so that buffers do not overlap. Directed cases cover a crossing from main to spare, a split inside the clamp region of a 4096-byte page with a 218-byte spare area, spare-only access, a start exactly at the page end and a zero-length request.

// File: rtl/nand_map_pkg.sv
package nand_map_pkg;

    // Shared geometry constants and defaults
    localparam int SECTOR_LOG       = 9;
    localparam int DEF_COL_W        = 16;
    localparam int DEF_LEN_W        = 16;
    localparam int DEF_SPARE_W      = 8;
    localparam int DEF_LOG_W        = 2;
    localparam int DEF_ADDR_W       = 13;
    localparam int DEF_NUM_SBUF     = 8;
    localparam int DEF_SBUF_STRIDE  = 64;
    localparam int DEF_SPARE_BASE   = 4096;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } map_state_e;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_map_geom.sv
module nand_map_geom
    import nand_map_pkg::*;
#(
    parameter int COL_W   = DEF_COL_W,
    parameter int SPARE_W = DEF_SPARE_W,
    parameter int LOG_W   = DEF_LOG_W
) (
    input  logic [LOG_W-1:0]   page_log2,
    input  logic [SPARE_W-1:0] spare_size,
    output logic [COL_W-1:0]   page_bytes,
    output logic [SPARE_W-1:0] share
);
    localparam logic [COL_W-1:0] SECTOR_BYTES = COL_W'(1) << SECTOR_LOG;

    assign page_bytes = SECTOR_BYTES << page_log2;
    // spare bytes per buffer, rounded down to an even count
    assign share      = (spare_size >> page_log2) & ~SPARE_W'(1);
endmodule

// File: rtl/nand_map_main.sv
module nand_map_main
    import nand_map_pkg::*;
#(
    parameter int COL_W  = DEF_COL_W,
    parameter int LEN_W  = DEF_LEN_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [COL_W-1:0]  col,
    input  logic [COL_W-1:0]  page_bytes,
    input  logic [LEN_W-1:0]  rem,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len,
    output logic              hits_end
);
    logic [COL_W-1:0] room;

    always_comb begin
        room     = page_bytes - col;
        hits_end = 32'(rem) >= 32'(room);
        len      = LEN_W'(umin(32'(rem), 32'(room)));
        addr     = ADDR_W'(col);
    end
endmodule

// File: rtl/nand_map_spare.sv
module nand_map_spare
    import nand_map_pkg::*;
#(
    parameter int COL_W       = DEF_COL_W,
    parameter int LEN_W       = DEF_LEN_W,
    parameter int SPARE_W     = DEF_SPARE_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int NUM_SBUF    = DEF_NUM_SBUF,
    parameter int SBUF_STRIDE = DEF_SBUF_STRIDE,
    parameter int SPARE_BASE  = DEF_SPARE_BASE,
    localparam int IDX_W      = $clog2(NUM_SBUF)
) (
    input  logic [COL_W-1:0]   soff,
    input  logic [SPARE_W-1:0] share,
    input  logic [LEN_W-1:0]   rem,
    output logic [ADDR_W-1:0]  addr,
    output logic [LEN_W-1:0]   len,
    output logic [IDX_W-1:0]   idx,
    output logic [COL_W-1:0]   off_in
);
    localparam int LAST = NUM_SBUF - 1;

    logic [COL_W-1:0] divisor;
    logic [COL_W-1:0] quot;

    always_comb begin
        divisor = (share == '0) ? COL_W'(1) : COL_W'(share);
        quot    = (share == '0) ? COL_W'(LAST) : soff / divisor;
        // clamp: everything past the last full share lands in the last buffer
        idx     = (quot > COL_W'(LAST)) ? IDX_W'(LAST) : IDX_W'(quot);
        off_in  = soff - COL_W'(idx) * COL_W'(share);
        if (idx == IDX_W'(LAST))
            len = rem;
        else
            len = LEN_W'(umin(32'(rem), 32'(COL_W'(share) - off_in)));
        addr    = ADDR_W'(SPARE_BASE) + ADDR_W'(idx) * ADDR_W'(SBUF_STRIDE) + ADDR_W'(off_in);
    end
endmodule

// File: rtl/nand_page_mapper.sv
module nand_page_mapper
    import nand_map_pkg::*;
#(
    parameter int COL_W       = DEF_COL_W,
    parameter int LEN_W       = DEF_LEN_W,
    parameter int SPARE_W     = DEF_SPARE_W,
    parameter int LOG_W       = DEF_LOG_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int NUM_SBUF    = DEF_NUM_SBUF,
    parameter int SBUF_STRIDE = DEF_SBUF_STRIDE,
    parameter int SPARE_BASE  = DEF_SPARE_BASE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COL_W-1:0]   req_col,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [LOG_W-1:0]   req_page_log2,
    input  logic [SPARE_W-1:0] req_spare_size,
    input  logic               req_spare_only,
    output logic               chunk_valid,
    input  logic               chunk_ready,
    output logic [ADDR_W-1:0]  chunk_addr,
    output logic [LEN_W-1:0]   chunk_len,
    output logic [COL_W-1:0]   col_out,
    output logic               done
);
    localparam int IDX_W = $clog2(NUM_SBUF);
    localparam int LAST  = NUM_SBUF - 1;

    typedef struct packed {
        logic             in_spare;
        logic [COL_W-1:0] soff;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] rem;
    } cursor_t;

    map_state_e         st;
    cursor_t            cur;
    logic [LOG_W-1:0]   log_q;
    logic [SPARE_W-1:0] spare_q;
    logic               done_q;

    logic [LOG_W-1:0]   g_log;
    logic [SPARE_W-1:0] g_spare;
    logic [COL_W-1:0]   page_bytes;
    logic [SPARE_W-1:0] share;

    logic [ADDR_W-1:0]  mn_addr, sp_addr;
    logic [LEN_W-1:0]   mn_len, sp_len;
    logic               mn_end;
    logic [IDX_W-1:0]   sp_idx;
    logic [COL_W-1:0]   sp_off;

    logic               accept, take;

    // geometry follows the request while idle, the captured values while running
    assign g_log   = (st == ST_IDLE) ? req_page_log2  : log_q;
    assign g_spare = (st == ST_IDLE) ? req_spare_size : spare_q;

    nand_map_geom #(.COL_W(COL_W), .SPARE_W(SPARE_W), .LOG_W(LOG_W)) u_geom (
        .page_log2 (g_log),
        .spare_size(g_spare),
        .page_bytes(page_bytes),
        .share     (share)
    );

    nand_map_main #(.COL_W(COL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_main (
        .col       (cur.col),
        .page_bytes(page_bytes),
        .rem       (cur.rem),
        .addr      (mn_addr),
        .len       (mn_len),
        .hits_end  (mn_end)
    );

    nand_map_spare #(
        .COL_W(COL_W), .LEN_W(LEN_W), .SPARE_W(SPARE_W), .ADDR_W(ADDR_W),
        .NUM_SBUF(NUM_SBUF), .SBUF_STRIDE(SBUF_STRIDE), .SPARE_BASE(SPARE_BASE)
    ) u_spare (
        .soff  (cur.soff),
        .share (share),
        .rem   (cur.rem),
        .addr  (sp_addr),
        .len   (sp_len),
        .idx   (sp_idx),
        .off_in(sp_off)
    );

    assign req_ready   = (st == ST_IDLE);
    assign chunk_valid = (st == ST_RUN);
    assign chunk_addr  = cur.in_spare ? sp_addr : mn_addr;
    assign chunk_len   = cur.in_spare ? sp_len  : mn_len;
    assign col_out     = cur.col;
    assign done        = done_q;
    assign accept      = req_valid && req_ready;
    assign take        = chunk_valid && chunk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            log_q   <= '0;
            spare_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                log_q   <= req_page_log2;
                spare_q <= req_spare_size;
                cur.col <= req_col;
                cur.rem <= req_len;
                if (req_col >= page_bytes) begin
                    cur.in_spare <= 1'b1;
                    cur.soff     <= req_col - page_bytes;
                end else if (req_spare_only) begin
                    cur.in_spare <= 1'b1;
                    cur.soff     <= req_col;
                end else begin
                    cur.in_spare <= 1'b0;
                    cur.soff     <= '0;
                end
                if (req_len == '0) done_q <= 1'b1;
                else               st     <= ST_RUN;
            end else if (take) begin
                cur.col <= cur.col + COL_W'(chunk_len);
                cur.rem <= cur.rem - chunk_len;
                if (cur.in_spare) begin
                    cur.soff <= cur.soff + COL_W'(chunk_len);
                end else if (mn_end) begin
                    cur.in_spare <= 1'b1;
                    cur.soff     <= '0;
                end
                if (cur.rem == chunk_len) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_main_bound_R2: assert property (@(posedge clk) disable iff (rst)
        chunk_valid && !cur.in_spare |-> 32'(cur.col) + 32'(chunk_len) <= 32'(page_bytes));

    assert_spare_entry_R3: assert property (@(posedge clk) disable iff (rst)
        take && !cur.in_spare && mn_end && (chunk_len != cur.rem) && (share != '0)
        |=> chunk_valid && chunk_addr == ADDR_W'(SPARE_BASE));

    assert_buf_bound_R7: assert property (@(posedge clk) disable iff (rst)
        chunk_valid && cur.in_spare && (sp_idx != IDX_W'(LAST))
        |-> 32'(sp_off) + 32'(chunk_len) <= 32'(share));

    assert_col_step_R8: assert property (@(posedge clk) disable iff (rst)
        take |=> col_out == $past(col_out) + COL_W'($past(chunk_len)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_addr) && $stable(chunk_len));

    assert_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> chunk_len != '0);

    assert_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && chunk_valid));

endmodule

// File: tb/nand_page_mapper_bench.sv
`timescale 1ns/1ps
module nand_page_mapper_bench;
    localparam int COL_W = 16, LEN_W = 16, SPARE_W = 8, LOG_W = 2, ADDR_W = 13;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [COL_W-1:0]   req_col = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [LOG_W-1:0]   req_page_log2 = '0;
    logic [SPARE_W-1:0] req_spare_size = '0;
    logic               req_spare_only = 1'b0;
    logic               chunk_valid;
    logic               chunk_ready = 1'b0;
    logic [ADDR_W-1:0]  chunk_addr;
    logic [LEN_W-1:0]   chunk_len;
    logic [COL_W-1:0]   col_out;
    logic               done;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    // model cursor
    int unsigned m_page, m_sb, m_col, m_soff, m_rem;
    bit m_sp;

    always #2 clk = ~clk;   // 250 MHz

    nand_page_mapper u_nand_page_mapper (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_col(req_col), .req_len(req_len),
        .req_page_log2(req_page_log2), .req_spare_size(req_spare_size),
        .req_spare_only(req_spare_only),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_addr(chunk_addr), .chunk_len(chunk_len),
        .col_out(col_out), .done(done)
    );

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned mn(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    // expected next chunk from the requirement formulas (R2, R6, R7)
    task automatic expect_chunk(output int unsigned e_addr, output int unsigned e_len);
        int unsigned k, o;
        if (!m_sp) begin
            e_addr = m_col & 32'h1FFF;
            e_len  = mn(m_rem, m_page - m_col);
        end else begin
            k = (m_sb == 0) ? 7 : m_soff / m_sb;
            if (k > 7) k = 7;
            o = m_soff - k * m_sb;
            e_len  = (k == 7) ? m_rem : mn(m_rem, m_sb - o);
            e_addr = (32'h1000 + k * 32'h40 + o) & 32'h1FFF;
        end
    endtask

    task automatic run_req(input int unsigned lg, input int unsigned spare, input int unsigned col,
                           input int unsigned len, input bit so, input string sp_tag);
        int unsigned e_addr, e_len, start_col;
        bit first_sp;
        int guard;
        m_page = 512 << lg;
        m_sb   = (spare >> lg) & ~32'd1;
        m_col  = col;
        m_rem  = len;
        start_col = col;
        if (col >= m_page)  begin m_sp = 1; m_soff = col - m_page; end
        else if (so)        begin m_sp = 1; m_soff = col;          end
        else                begin m_sp = 0; m_soff = 0;            end
        first_sp = 1;

        @(negedge clk);
        req_valid      = 1'b1;
        req_col        = COL_W'(col);
        req_len        = LEN_W'(len);
        req_page_log2  = LOG_W'(lg);
        req_spare_size = SPARE_W'(spare);
        req_spare_only = so;
        @(negedge clk);
        req_valid = 1'b0;

        if (len == 0) begin
            check(done == 1'b1, "R10 zero-length done", 32'(done), 1);
            check(chunk_valid == 1'b0, "R10 zero-length no chunk", 32'(chunk_valid), 0);
            @(negedge clk);
            check(done == 1'b0, "R10 done one cycle", 32'(done), 0);
            return;
        end

        guard = 0;
        while (m_rem > 0 && guard < 64) begin
            guard++;
            expect_chunk(e_addr, e_len);
            check(chunk_valid == 1'b1, "R10 chunk offered", 32'(chunk_valid), 1);
            check(done == 1'b0, "R10 no early done", 32'(done), 0);
            if (!m_sp) begin
                check(32'(chunk_addr) == e_addr, "R2 main address", 32'(chunk_addr), e_addr);
                check(32'(chunk_len)  == e_len,  "R2 main length",  32'(chunk_len),  e_len);
            end else begin
                check(32'(chunk_addr) == e_addr, first_sp ? sp_tag : "R6 spare address",
                      32'(chunk_addr), e_addr);
                check(32'(chunk_len)  == e_len,  "R7 spare length", 32'(chunk_len), e_len);
                first_sp = 0;
            end
            if ($urandom % 4 == 0) begin
                chunk_ready = 1'b0;
                @(negedge clk);
                check(chunk_valid && 32'(chunk_addr) == e_addr && 32'(chunk_len) == e_len,
                      "R9 hold while stalled", 32'(chunk_addr), e_addr);
            end
            chunk_ready = 1'b1;
            @(negedge clk);
            chunk_ready = 1'b0;
            m_col += e_len;
            m_rem -= e_len;
            if (m_sp) m_soff += e_len;
            else if (m_col == m_page) begin m_sp = 1; m_soff = 0; end
            if (m_rem > 0)
                check(32'(col_out) == m_col, "R8 running column", 32'(col_out), m_col);
        end
        check(done == 1'b1, "R10 done after last chunk", 32'(done), 1);
        check(chunk_valid == 1'b0, "R10 idle after done", 32'(chunk_valid), 0);
        check(32'(col_out) == ((start_col + len) & 32'hFFFF), "R8 final column",
              32'(col_out), (start_col + len) & 32'hFFFF);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1,   "R1 reset req_ready",   32'(req_ready), 1);
        check(chunk_valid == 1'b0, "R1 reset chunk_valid", 32'(chunk_valid), 0);
        check(done == 1'b0,        "R1 reset done",        32'(done), 0);
        check(col_out == '0,       "R1 reset col_out",     32'(col_out), 0);

        // main to spare crossing, 512-byte page, 16 spare
        run_req(0, 16, 500, 40, 0, "R3 spare after main");
        // 4096 page, 218 spare: split near clamp into buffer 7
        run_req(3, 218, 4096 + 180, 38, 0, "R4 start past page");
        // spare-only below page size
        run_req(2, 128, 10, 5, 1, "R5 spare-only offset");
        // start exactly at page end
        run_req(1, 64, 1024, 20, 0, "R4 start at page end");
        // zero length
        run_req(1, 64, 100, 0, 0, "R6 spare address");
        // whole 2048 page plus spare
        run_req(2, 64, 0, 2048 + 64, 0, "R3 spare after main");

        for (int i = 0; i < 60; i++) begin
            int unsigned lg, mx, spare, col, len;
            bit so;
            lg    = $urandom % 4;
            mx    = (64 << lg) > 255 ? 255 : (64 << lg);
            spare = 16 + ($urandom % (mx - 15));
            col   = $urandom % ((512 << lg) + spare);
            len   = ($urandom % 8 == 0) ? 0 : $urandom % 600;
            so    = ($urandom % 10 == 0);
            run_req(lg, spare, col, len, so, "R6 spare address");
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule